// File: doc/BRIEF.md
# PLL Fastlock Charge-Pump Controller

This controller shortens PLL frequency hops by selecting the high charge-pump current for a while after a new divider setting is written. Software sets it up with three configuration inputs: an enable flag, a mode flag and a 4-bit timeout code. A gain bit then comes in with every divider-counter write. Writing the gain bit as 1 starts fastlock. In fastlock the controller selects high current and pulls the fast-lock pin low, which switches a resistor in the loop filter.

Fastlock can end in one of two ways. In software-exit mode it ends when the gain bit is written back to 0. In timer-exit mode a timeout counter runs on ticks from the reference divider. When the timeout expires, the controller goes back to low current and pulses a clear strobe so the counter register resets its gain bit. When fastlock is disabled, the fast-lock pin acts as a plain output and follows the mode flag. A power-down input cancels fastlock and returns the timeout counter to its load state.

Top module: `fastlock_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, cp_hi_o is 0 and gain_clr_o is 0.
- R2: While fl_en_i is 0, gain writes have no effect and cp_hi_o is 0 from the cycle after a sampling edge with fl_en_i at 0. This holds even if fastlock was running, and no clear strobe is produced.
- R3: With fl_en_i at 1 and pwr_dn_i at 0, a clock edge that samples gain_wr_i=1 with gain_bit_i=1 sets cp_hi_o to 1 (1 = high current) from the next cycle.
- R4: With fl_mode_i at 0 (software exit), fastlock stays active until an edge samples gain_wr_i=1 with gain_bit_i=0. cp_hi_o is 0 after that edge, and no clear strobe is produced.
- R5: flo_o is 0 whenever cp_hi_o is 1. Otherwise it equals fl_mode_i.
- R6: With fl_mode_i at 1 (timer exit), fastlock lasts exactly (tc_code_i+1)*4 sampled ref_tick_i pulses, counted from the edge after entry. cp_hi_o falls right after the edge that samples the last of these pulses.
- R7: When the timeout expires, gain_clr_o is 1 for exactly one cycle, and that cycle is the first cycle with cp_hi_o back at 0. The strobe is never produced in any other case.
- R8: A gain write of 1 while timer-exit fastlock is running reloads the timeout from tc_code_i and restarts the count. If it arrives on the same edge as a tick, the write wins.
- R9: In timer-exit mode, a gain write of 0 is ignored, and a tick sampled on that same edge is still counted.
- R10: An edge that samples pwr_dn_i=1 ends fastlock without a strobe, reloads the timer, and causes gain writes on that edge to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fl_en_i | input | 1 | Fastlock enable from configuration |
| fl_mode_i | input | 1 | 0 software exit, 1 timer exit; pin level when disabled |
| tc_code_i | input | 4 | Timeout code |
| gain_wr_i | input | 1 | Divider-counter register write strobe |
| gain_bit_i | input | 1 | Gain bit value carried with the write |
| ref_tick_i | input | 1 | One-cycle tick per reference-divider period |
| pwr_dn_i | input | 1 | Power-down |
| cp_hi_o | output | 1 | Charge-pump select, 1 high current |
| flo_o | output | 1 | Fast-lock pin level |
| gain_clr_o | output | 1 | One-cycle strobe that clears the gain bit |

## Verification
The assertions check every cycle that the pin level is consistent with the current select, that a clear strobe lasts one cycle and coincides with the fall of the select, and that a disable or a power-down always ends fastlock. They also check that a gain write of 1 always enters fastlock and that software-exit fastlock is held until a gain write of 0. The exact timeout length for each code, reloading on a repeat write, the priority of a write over a tick on the same edge, and the ignored zero write in timer mode can only be shown by the bench scenarios. The bench does this by comparing against a cycle model under random traffic.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int unsigned TC_W        = 4;
  localparam int unsigned STEP_TICKS  = 4;
  typedef enum logic {EXIT_SW = 1'b0, EXIT_TIMER = 1'b1} exit_mode_e;
endpackage

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int unsigned TC_W       = fl_pkg::TC_W,
  parameter int unsigned STEP_TICKS = fl_pkg::STEP_TICKS,
  localparam int unsigned MAX_CNT   = (2 ** TC_W) * STEP_TICKS,
  localparam int unsigned CNT_W     = $clog2(MAX_CNT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            clear_i,
  input  logic            step_i,
  input  logic [TC_W-1:0] code_i,
  output logic            done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;

  assign load_val = (CNT_W'(code_i) + CNT_W'(1)) * CNT_W'(STEP_TICKS);
  assign done_o   = step_i && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)               cnt_d = '0;
    else if (load_i)           cnt_d = load_val;
    else if (step_i && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fl_core.sv
module fl_core
  import fl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  exit_mode_e mode_i,
  input  logic       wr_i,
  input  logic       bit_i,
  input  logic       tick_i,
  input  logic       pd_i,
  input  logic       tmr_done_i,
  output logic       tmr_load_o,
  output logic       tmr_clear_o,
  output logic       tmr_step_o,
  output logic       active_o,
  output logic       clr_o
);
  logic active_q, active_d, clr_q, clr_d;
  logic kill, enter, sw_exit;

  assign kill        = !en_i || pd_i;
  assign enter       = !kill && wr_i && bit_i;
  assign sw_exit     = !kill && wr_i && !bit_i && (mode_i == EXIT_SW);
  assign tmr_clear_o = kill;
  assign tmr_load_o  = enter;
  // write beats tick; zero write in timer mode falls through to counting
  assign tmr_step_o  = !kill && !enter && !sw_exit && active_q &&
                       (mode_i == EXIT_TIMER) && tick_i;

  always_comb begin
    active_d = active_q;
    clr_d    = 1'b0;
    if (kill)                   active_d = 1'b0;
    else if (enter)             active_d = 1'b1;
    else if (sw_exit)           active_d = 1'b0;
    else if (tmr_done_i) begin
      active_d = 1'b0;
      clr_d    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      clr_q    <= clr_d;
    end
  end

  assign active_o = active_q;
  assign clr_o    = clr_q;
endmodule

// File: rtl/fl_pin.sv
module fl_pin (
  input  logic active_i,
  input  logic mode_i,
  output logic cp_hi_o,
  output logic flo_o
);
  assign cp_hi_o = active_i;
  assign flo_o   = active_i ? 1'b0 : mode_i;
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl
  import fl_pkg::*;
#(
  parameter int unsigned TC_BITS = fl_pkg::TC_W,
  parameter int unsigned TICKS   = fl_pkg::STEP_TICKS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fl_en_i,
  input  logic               fl_mode_i,
  input  logic [TC_BITS-1:0] tc_code_i,
  input  logic               gain_wr_i,
  input  logic               gain_bit_i,
  input  logic               ref_tick_i,
  input  logic               pwr_dn_i,
  output logic               cp_hi_o,
  output logic               flo_o,
  output logic               gain_clr_o
);
  logic tmr_load, tmr_clear, tmr_step, tmr_done, active;
  exit_mode_e mode;

  assign mode = exit_mode_e'(fl_mode_i);

  fl_timer #(.TC_W(TC_BITS), .STEP_TICKS(TICKS)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .clear_i (tmr_clear),
    .step_i  (tmr_step),
    .code_i  (tc_code_i),
    .done_o  (tmr_done)
  );

  fl_core i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (fl_en_i),
    .mode_i      (mode),
    .wr_i        (gain_wr_i),
    .bit_i       (gain_bit_i),
    .tick_i      (ref_tick_i),
    .pd_i        (pwr_dn_i),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .tmr_clear_o (tmr_clear),
    .tmr_step_o  (tmr_step),
    .active_o    (active),
    .clr_o       (gain_clr_o)
  );

  fl_pin i_pin (
    .active_i (active),
    .mode_i   (fl_mode_i),
    .cp_hi_o  (cp_hi_o),
    .flo_o    (flo_o)
  );
endmodule

// File: rtl/fastlock_ctrl_chk.sv
module fastlock_ctrl_chk #(
  parameter int unsigned TC_BITS = 4,
  parameter int unsigned TICKS   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fl_en_i,
  input logic               fl_mode_i,
  input logic [TC_BITS-1:0] tc_code_i,
  input logic               gain_wr_i,
  input logic               gain_bit_i,
  input logic               ref_tick_i,
  input logic               pwr_dn_i,
  input logic               cp_hi_o,
  input logic               flo_o,
  input logic               gain_clr_o
);
  assert_disabled_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_en_i |=> !cp_hi_o && !gain_clr_o);

  assert_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_en_i && !pwr_dn_i && gain_wr_i && gain_bit_i |=> cp_hi_o);

  assert_sw_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_en_i && !fl_mode_i && !pwr_dn_i && cp_hi_o && !gain_wr_i |=> cp_hi_o);

  assert_pin_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_hi_o |-> !flo_o);

  assert_pin_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cp_hi_o |-> flo_o == fl_mode_i);

  assert_strobe_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_clr_o |-> !cp_hi_o && $past(cp_hi_o));

  assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_clr_o |=> !gain_clr_o);

  assert_zero_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_en_i && fl_mode_i && !pwr_dn_i && cp_hi_o && gain_wr_i && !gain_bit_i
    && !ref_tick_i |=> cp_hi_o);

  assert_powerdown_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |=> !cp_hi_o && !gain_clr_o);
endmodule

bind fastlock_ctrl fastlock_ctrl_chk #(.TC_BITS(TC_BITS), .TICKS(TICKS)) i_chk (.*);

// File: tb/test_fastlock_ctrl.sv
`timescale 1ns/1ps
module test_fastlock_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 0, mode = 0, wr = 0, gbit = 0, tick = 0, pd = 0;
  logic [3:0] code = '0;
  logic cp_hi, flo, clr;
  int total = 0, bad = 0;

  // reference model state
  logic m_act = 0, m_clr = 0;
  int   m_cnt = 0;

  always #5 clk = ~clk;

  fastlock_ctrl i_fastlock_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .fl_en_i(en), .fl_mode_i(mode),
    .tc_code_i(code), .gain_wr_i(wr), .gain_bit_i(gbit),
    .ref_tick_i(tick), .pwr_dn_i(pd),
    .cp_hi_o(cp_hi), .flo_o(flo), .gain_clr_o(clr));

  function automatic int tmo(input logic [3:0] c);
    return (int'(c) + 1) * 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    m_clr = 0;
    if (!rst_ni) begin m_act = 0; m_cnt = 0; end
    else if (!en || pd) begin m_act = 0; m_cnt = 0; end
    else if (wr && gbit) begin m_act = 1; m_cnt = tmo(code); end
    else if (wr && !gbit && !mode) m_act = 0;
    else if (m_act && mode && tick) begin
      if (m_cnt == 1) begin m_act = 0; m_clr = 1; m_cnt = 0; end
      else m_cnt--;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R3 cp_hi model", int'(cp_hi), int'(m_act));
    chk("R5 flo model", int'(flo), m_act ? 0 : int'(mode));
    chk("R7 clr model", int'(clr), int'(m_clr));
  endtask

  task automatic idle_in();
    wr = 0; gbit = 0; tick = 0; pd = 0;
  endtask

  task automatic write_gain(input logic b);
    wr = 1; gbit = b; step(); wr = 0; gbit = 0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    @(negedge clk);
    chk("R1 reset cp_hi", int'(cp_hi), 0);
    chk("R1 reset clr", int'(clr), 0);
    @(negedge clk); rst_ni = 1'b1;
    step();
    chk("R1 first cycle cp_hi", int'(cp_hi), 0);

    // R2: disabled, writes ignored, pin follows mode
    en = 0; mode = 1; write_gain(1);
    chk("R2 disabled write", int'(cp_hi), 0);
    chk("R5 disabled pin", int'(flo), 1);
    mode = 0; step();
    chk("R5 disabled pin low", int'(flo), 0);

    // R4: software exit
    en = 1; mode = 0; write_gain(1);
    chk("R3 entered", int'(cp_hi), 1);
    chk("R5 pin low in fastlock", int'(flo), 0);
    tick = 1; for (int i = 0; i < 80; i++) step(); tick = 0;
    chk("R4 held without zero write", int'(cp_hi), 1);
    write_gain(0);
    chk("R4 exit on zero write", int'(cp_hi), 0);
    chk("R4 no strobe", int'(clr), 0);

    // R6/R7: timer exit, code 2 -> 12 ticks
    mode = 1; code = 4'd2; write_gain(1);
    tick = 1;
    for (int i = 0; i < 11; i++) step();
    chk("R6 before expiry", int'(cp_hi), 1);
    step();
    chk("R6 expired after 12 ticks", int'(cp_hi), 0);
    chk("R7 strobe on expiry", int'(clr), 1);
    tick = 0; step();
    chk("R7 strobe one cycle", int'(clr), 0);

    // R8: reload, write wins over tick
    code = 4'd0; write_gain(1);
    tick = 1; step(); step(); step();
    wr = 1; gbit = 1; step(); wr = 0; gbit = 0;
    for (int i = 0; i < 3; i++) step();
    chk("R8 reloaded still active", int'(cp_hi), 1);
    step();
    chk("R8 expiry after reload", int'(cp_hi), 0);

    // R9: zero write ignored, tick on same edge counted
    tick = 0; code = 4'd0; write_gain(1);
    tick = 1; step(); step();
    wr = 1; gbit = 0; step(); wr = 0;
    chk("R9 zero write ignored", int'(cp_hi), 1);
    step();
    chk("R9 tick counted with zero write", int'(cp_hi), 0);
    tick = 0;

    // R2: disable mid-fastlock
    code = 4'd15; write_gain(1);
    en = 0; step();
    chk("R2 disable ends fastlock", int'(cp_hi), 0);
    chk("R2 no strobe", int'(clr), 0);
    en = 1;

    // R10: power-down
    write_gain(1);
    pd = 1; wr = 1; gbit = 1; step(); wr = 0; gbit = 0;
    chk("R10 power-down ends", int'(cp_hi), 0);
    chk("R10 no strobe", int'(clr), 0);
    pd = 0; code = 4'd1; write_gain(1); tick = 1;
    for (int i = 0; i < 7; i++) step();
    chk("R10 timer reloaded", int'(cp_hi), 1);
    step();
    chk("R10 fresh timeout", int'(cp_hi), 0);

    // random traffic against model
    for (int i = 0; i < 6000; i++) begin
      en   = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 49) == 0) mode = $urandom_range(0, 1);
      code = 4'($urandom_range(0, 3));
      wr   = ($urandom_range(0, 24) == 0);
      gbit = ($urandom_range(0, 2) != 0);
      tick = ($urandom_range(0, 1) == 1);
      pd   = ($urandom_range(0, 99) == 0);
      step();
    end
    idle_in();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule